// File: doc/BRIEF.md
# Pipelined Gaussian Noise Generator

This block is a free-running source of noise with a roughly bell-shaped distribution. It emits one signed 12-bit sample on every clock cycle. Four independent pseudorandom lanes each supply a uniformly distributed 10-bit value. By the central limit theorem, the sum of the four values falls close to a normal distribution. Each lane is a 31-bit maximal-style shift register with two feedback taps, and each lane has its own fixed starting value.

Two registered adder stages form the sum. The first stage adds lanes 0 and 1 in one adder and lanes 2 and 3 in a second adder. The second stage adds the two partial sums. Because the adders run in parallel, a fresh sample leaves the block on every clock cycle.

A small state machine tracks the pipeline fill after reset and drives the valid flag. Its states are:
- `FILL_A`: the first cycle after reset.
- `FILL_B`: the second cycle after reset.
- `RUN`: the steady state.

Its transitions are:
- `FILL_A` to `FILL_B` on the first clock edge with reset low.
- `FILL_B` to `RUN` on the next clock edge with reset low.
- `RUN` stays in `RUN` while reset is low.
- Any state goes to `FILL_A` on a clock edge with reset high.

Top module: `ngx_gauss_gen`

## Requirements
- R1: On every clock edge with reset low, each lane register shifts one place toward bit 0. The new bit 30 is the XNOR of the old bits 0 and 3.
- R2: A clock edge with reset high loads the lane registers with these seeds, written as 31-bit unsigned values:
  - lane 0: 697757461
  - lane 1: 1885540239
  - lane 2: 1505946904
  - lane 3: 2693445
- R3: Each lane contributes its bits [9:0], read as a two's-complement value. That value is sign-extended to 12 bits by copying bit 9 into bits 10 and 11.
- R4: `sample_o` is the 12-bit two's-complement sum of the four sign-extended lane values, wrapping on overflow.
- R5: The sample visible after the k-th edge with reset low (k ≥ 2) is formed from the lane states held after edge k−2. For example, the first valid sample after reset comes from the seeds and equals 257.
- R6: `valid_o` is low after a reset edge. It stays low after the first following edge with reset low. It is high from the second such edge on, and stays high until the next reset.
- R7: After a clock edge with reset high, `sample_o` is 0 and `valid_o` is 0.
- R8: All four lanes advance together on every clock edge with reset low, so a new sample appears on every cycle.
- R9: A reset applied at any moment, including during the fill cycles, restarts the sample sequence exactly from its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample_o | output | 12 | Signed noise sample |
| valid_o | output | 1 | High when `sample_o` holds a real sample |

## Verification
The hardest cases to reach from the ports are restarts in mid-flight. Reset may arrive while the pipeline is still filling, or last a single cycle, or fall exactly when `valid_o` would have risen. In each case the partial sums still inside the adder stages must be discarded, and the sequence must restart cleanly.

The stimulus uses a fixed-seed random generator to pick how long each run lasts and how long each reset pulse is held. Many runs are drawn only zero to three cycles long, so that resets land inside `FILL_A` and `FILL_B`. Each restart is compared with a bench model of the four lanes. A directed check also confirms that the first sample after every reset equals the value computed from the seeds.

// File: rtl/ngx_pkg.sv
package ngx_pkg;
    localparam int LFSR_W  = 31;
    localparam int UNI_W   = 10;
    localparam int OUT_W   = 12;
    localparam int LANES   = 4;
    localparam int TAP_LO  = 0;
    localparam int TAP_HI  = 3;
    localparam int EXT_W   = OUT_W - UNI_W;

    typedef enum logic [1:0] {
        FILL_A = 2'd0,
        FILL_B = 2'd1,
        RUN    = 2'd2
    } fill_state_t;

    function automatic logic [LFSR_W-1:0] lane_seed(input int idx);
        case (idx)
            0:       return LFSR_W'(697757461);
            1:       return LFSR_W'(1885540239);
            2:       return LFSR_W'(1505946904);
            default: return LFSR_W'(2693445);
        endcase
    endfunction

    function automatic logic [OUT_W-1:0] widen(input logic [UNI_W-1:0] u);
        return {{EXT_W{u[UNI_W-1]}}, u};
    endfunction
endpackage

// File: rtl/ngx_lfsr.sv
module ngx_lfsr
    import ngx_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = '1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] state_o
);
    logic fb;

    assign fb = ~(state_o[TAP_LO] ^ state_o[TAP_HI]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= SEED;
        end else begin
            state_o <= {fb, state_o[LFSR_W-1:1]};
        end
    end
endmodule

// File: rtl/ngx_add_reg.sv
module ngx_add_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sum_o <= '0;
        end else begin
            sum_o <= a_i + b_i;
        end
    end
endmodule

// File: rtl/ngx_fill_ctl.sv
module ngx_fill_ctl
    import ngx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic valid_o
);
    fill_state_t cur, nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= FILL_A;
        end else begin
            cur <= nxt;
        end
    end

    always_comb begin
        nxt = cur;
        unique case (cur)
            FILL_A:  nxt = FILL_B;
            FILL_B:  nxt = RUN;
            RUN:     nxt = RUN;
            default: nxt = FILL_A;
        endcase
    end

    always_comb begin
        valid_o = 1'b0;
        unique case (cur)
            FILL_A, FILL_B: valid_o = 1'b0;
            RUN:            valid_o = 1'b1;
            default:        valid_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ngx_gauss_gen.sv
module ngx_gauss_gen
    import ngx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] sample_o,
    output logic             valid_o
);
    localparam int PAIRS = LANES / 2;

    logic [LANES-1:0][LFSR_W-1:0] lane_state;
    logic [LANES-1:0][OUT_W-1:0]  lane_ext;
    logic [PAIRS-1:0][OUT_W-1:0]  part_sum;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        ngx_lfsr #(.SEED(lane_seed(i))) u_lfsr (
            .clk     (clk),
            .rst     (rst),
            .state_o (lane_state[i])
        );
        assign lane_ext[i] = widen(lane_state[i][UNI_W-1:0]);
    end

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        ngx_add_reg #(.W(OUT_W)) u_add (
            .clk   (clk),
            .rst   (rst),
            .a_i   (lane_ext[2*p]),
            .b_i   (lane_ext[2*p+1]),
            .sum_o (part_sum[p])
        );
    end

    ngx_add_reg #(.W(OUT_W)) u_final (
        .clk   (clk),
        .rst   (rst),
        .a_i   (part_sum[0]),
        .b_i   (part_sum[1]),
        .sum_o (sample_o)
    );

    ngx_fill_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .valid_o (valid_o)
    );
endmodule

// File: rtl/ngx_gauss_gen_chk.sv
module ngx_gauss_gen_chk
    import ngx_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic [OUT_W-1:0]             sample_o,
    input logic                         valid_o,
    input logic [LANES-1:0][LFSR_W-1:0] lane_state
);
    logic       seen;
    logic [1:0] live;
    logic [OUT_W-1:0] lane_sum;

    always_ff @(posedge clk) begin
        seen <= (seen === 1'b1) || rst;
        if (rst) begin
            live <= 2'd0;
        end else if (live < 2'd2) begin
            live <= live + 2'd1;
        end
    end

    always_comb begin
        lane_sum = '0;
        for (int i = 0; i < LANES; i++) begin
            lane_sum = lane_sum + widen(lane_state[i][UNI_W-1:0]);
        end
    end

    AST_ZERO_IN_RESET: assert property (@(posedge clk) disable iff (seen !== 1'b1)
        $past(rst) |-> (sample_o == '0 && !valid_o)); // R7

    AST_VALID_FILL: assert property (@(posedge clk) disable iff (rst || seen !== 1'b1)
        valid_o == (live >= 2'd2)); // R6

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst || seen !== 1'b1)
        valid_o |=> valid_o); // R6

    AST_SUM_LATENCY: assert property (@(posedge clk) disable iff (rst || seen !== 1'b1)
        (live >= 2'd2) |-> sample_o == $past(lane_sum, 2)); // R5

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        AST_LANE_SHIFT: assert property (@(posedge clk) disable iff (rst || seen !== 1'b1)
            (live >= 2'd1) |-> (lane_state[i][LFSR_W-2:0] == $past(lane_state[i][LFSR_W-1:1])
                && lane_state[i][LFSR_W-1] == ~($past(lane_state[i][TAP_LO]) ^ $past(lane_state[i][TAP_HI])))); // R1
    end
endmodule

bind ngx_gauss_gen ngx_gauss_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_o   (sample_o),
    .valid_o    (valid_o),
    .lane_state (lane_state)
);

// File: tb/ngx_gauss_gen_bench.sv
module ngx_gauss_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] sample_o;
    logic        valid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [30:0] m_lane [4];
    logic [11:0] m_pend;
    logic [11:0] m_out;
    int          m_since;

    localparam logic [30:0] SEEDS [4] = '{31'd697757461, 31'd1885540239, 31'd1505946904, 31'd2693445};

    always #4 clk = ~clk;

    ngx_gauss_gen u_ngx_gauss_gen (
        .clk      (clk),
        .rst      (rst),
        .sample_o (sample_o),
        .valid_o  (valid_o)
    );

    function automatic logic [30:0] step_lane(input logic [30:0] x);
        return {~(x[0] ^ x[3]), x[30:1]};
    endfunction

    function automatic logic [11:0] total(input logic [30:0] a, b, c, d);
        logic [11:0] s;
        s = {{2{a[9]}}, a[9:0]} + {{2{b[9]}}, b[9:0]};
        s = s + {{2{c[9]}}, c[9:0]} + {{2{d[9]}}, d[9:0]};
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock edge with the given reset level, model update, then compare at the falling edge.
    task automatic cycle(input bit r);
        rst = r;
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 4; i++) m_lane[i] = SEEDS[i]; // R2
            m_pend = '0; m_out = '0; m_since = 0;
        end else begin
            m_out  = m_pend;
            m_pend = total(m_lane[0], m_lane[1], m_lane[2], m_lane[3]); // R3 R4
            for (int i = 0; i < 4; i++) m_lane[i] = step_lane(m_lane[i]); // R1 R8
            if (m_since < 2) m_since++;
        end
        @(negedge clk);
        if (r) begin
            check(sample_o == 12'd0, "R7 sample in reset", int'(sample_o), 0);
            check(valid_o == 1'b0, "R7 valid in reset", int'(valid_o), 0);
        end else begin
            check(valid_o == (m_since >= 2), "R6 valid", int'(valid_o), int'(m_since >= 2));
            check(sample_o == m_out, "R4 R5 R9 sample", int'($signed(sample_o)), int'($signed(m_out)));
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int runlen, rstlen;
        void'($urandom(32'h5EED_0041));
        @(negedge clk);
        for (int i = 0; i < 3; i++) cycle(1'b1);
        cycle(1'b0);
        cycle(1'b0);
        // R2 R3 R5: first valid sample is built from the seeds: -235 - 113 + 280 + 325 = 257
        check(sample_o == 12'd257 && valid_o, "R2 R3 R5 first sample", int'($signed(sample_o)), 257);
        for (int i = 0; i < 400; i++) cycle(1'b0); // R8 per-cycle throughput
        // Directed: single-cycle reset landing exactly when valid would rise
        cycle(1'b1);
        cycle(1'b0);
        cycle(1'b1);
        cycle(1'b0);
        cycle(1'b0);
        check(sample_o == 12'd257, "R9 restart after fill reset", int'($signed(sample_o)), 257);
        // Random run/reset mix, many runs short enough to hit the fill states
        for (int k = 0; k < 60; k++) begin
            runlen = ($urandom % 3 == 0) ? int'($urandom % 4) : int'($urandom % 150);
            rstlen = 1 + int'($urandom % 3);
            for (int i = 0; i < rstlen; i++) cycle(1'b1);
            for (int i = 0; i < runlen; i++) cycle(1'b0);
        end
        for (int i = 0; i < 50; i++) cycle(1'b0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule